// File: doc/BRIEF.md
# Programmable Hub Slot Arbiter

This block decides, once per hub cycle, which of up to 32 processor cores may use one shared memory port. A free-running slot counter walks through a 128-entry ownership table that software can rewrite. Each table entry names the core that owns that slot. If the owning core is enabled and requesting, it gets the slot. If it is not, the slot is lent to a requesting, enabled core that owns no entries at all. Such a core is called a moocher. When there are several moochers, a rotating pointer chooses among them so that none waits forever.

A core that owns slots gets fully deterministic access, because the slot sequence repeats every 128 cycles. A core that owns nothing gets only the slots that other cores leave unused. The grant is combinational in the cycle of the request, so a stalled core resumes in the same cycle its grant appears. The grant path has three outcomes: GK_OWNER (the owner takes its slot), GK_MOOCH (a leftover slot is lent) and GK_NONE (no eligible request). Only the GK_MOOCH outcome moves the rotating pointer. A table write is stored at the clock edge and counts from the next slot on.

Top module: `hub_slot_arbiter`

## Requirements
- R1: After reset the slot index is 0 and no grant is asserted. Table entry i is owned by core i mod 32. The rotating pointer starts at core 0.
- R2: The slot index goes up by one every cycle and wraps from 127 to 0.
- R3: When the owner of the current slot is requesting and enabled, that owner alone is granted.
- R4: When the owner is idle or disabled, the slot goes only to a requesting, enabled core that owns zero entries. A core that owns some entries gets no grant in slots it does not own.
- R5: Moochers are served in rotating order. The first eligible core is searched from the pointer upward, wrapping at 31. After each lent slot the pointer becomes the winner plus one, modulo 32.
- R6: A core whose enable bit is 0 is never granted.
- R7: The grant vector has at most one bit set, and it is all zero when no request is eligible.
- R8: A table write in cycle t, with address in tbl_addr and core number in tbl_owner, does not change the grant of cycle t. It governs that slot from cycle t+1 on.
- R9: Ownership counts follow the writes. A core whose last entry is rewritten becomes a moocher. A moocher that is written into any entry stops being one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Hub clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 32 | Access request, one bit per core |
| core_en | input | 32 | Core enable mask, one bit per core |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 7 | Table entry to write |
| tbl_owner | input | 5 | Core number stored into the entry |
| core_grant | output | 32 | One-hot (or zero) grant for the current slot |
| slot_idx | output | 7 | Current slot index |

## Verification
A table rewrite and the grant can fall in the same cycle. The case that matters is a write aimed at the entry that is being arbitrated right now. The bench provokes this by writing a new owner into the current slot while both the old owner and the new owner request. It expects the old owner to win that cycle. The reference model runs every cycle, applies each write only after it has compared the grant, and so judges both this case and the later slots that the new owner now holds.

// File: rtl/hub_arb_pkg.sv
`timescale 1ns/1ps
package hub_arb_pkg;
    typedef enum logic [1:0] {
        GK_NONE  = 2'd0,
        GK_OWNER = 2'd1,
        GK_MOOCH = 2'd2
    } grant_kind_e;
endpackage

// File: rtl/slot_table.sv
`timescale 1ns/1ps
module slot_table #(
    parameter int NUM_CORES = 32,
    parameter int NUM_SLOTS = 128,
    parameter int CORE_W    = 5,
    parameter int SLOT_W    = 7,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SLOT_W-1:0]    waddr,
    input  logic [CORE_W-1:0]    wowner,
    input  logic [SLOT_W-1:0]    raddr,
    output logic [CORE_W-1:0]    rowner,
    output logic [NUM_CORES-1:0] owns_none
);
    logic [CORE_W-1:0] tbl [NUM_SLOTS];
    logic [CNT_W-1:0]  cnt [NUM_CORES];

    function automatic logic [CNT_W-1:0] init_cnt(input int c);
        int n;
        n = 0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (i % NUM_CORES == c) n++;
        end
        return CNT_W'(n);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) tbl[i] <= CORE_W'(i % NUM_CORES);
            for (int c = 0; c < NUM_CORES; c++) cnt[c] <= init_cnt(c);
        end else if (we) begin
            tbl[waddr] <= wowner;
            if (tbl[waddr] != wowner) begin
                cnt[tbl[waddr]] <= cnt[tbl[waddr]] - 1'b1;
                cnt[wowner]     <= cnt[wowner] + 1'b1;
            end
        end
    end

    assign rowner = tbl[raddr];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_none
        assign owns_none[c] = (cnt[c] == '0);
    end
endmodule

// File: rtl/mooch_picker.sv
`timescale 1ns/1ps
module mooch_picker #(
    parameter int NUM_CORES = 32,
    parameter int CORE_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] elig,
    input  logic                 advance,
    output logic                 pick_valid,
    output logic [CORE_W-1:0]    pick_idx
);
    localparam int CW1 = CORE_W + 1;

    logic [CORE_W-1:0] ptr_q;

    always_comb begin
        logic [CW1-1:0] s;
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int k = 0; k < NUM_CORES; k++) begin
            s = {1'b0, ptr_q} + CW1'(k);
            if (s >= CW1'(NUM_CORES)) s = s - CW1'(NUM_CORES);
            if (!pick_valid && elig[s[CORE_W-1:0]]) begin
                pick_valid = 1'b1;
                pick_idx   = s[CORE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (pick_idx == CORE_W'(NUM_CORES - 1)) ? '0 : pick_idx + 1'b1;
        end
    end

    AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> elig[pick_idx]); // R5
endmodule

// File: rtl/hub_slot_arbiter.sv
`timescale 1ns/1ps
module hub_slot_arbiter
    import hub_arb_pkg::*;
#(
    parameter int NUM_CORES = 32,
    parameter int NUM_SLOTS = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CORES-1:0]         core_req,
    input  logic [NUM_CORES-1:0]         core_en,
    input  logic                         tbl_we,
    input  logic [$clog2(NUM_SLOTS)-1:0] tbl_addr,
    input  logic [$clog2(NUM_CORES)-1:0] tbl_owner,
    output logic [NUM_CORES-1:0]         core_grant,
    output logic [$clog2(NUM_SLOTS)-1:0] slot_idx
);
    localparam int CORE_W = $clog2(NUM_CORES);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1);
    localparam logic [NUM_CORES-1:0] ONE = {{(NUM_CORES-1){1'b0}}, 1'b1};

    logic [SLOT_W-1:0]    slot_q;
    logic [CORE_W-1:0]    owner;
    logic [NUM_CORES-1:0] owns_none;
    logic [NUM_CORES-1:0] elig;
    logic                 pick_valid;
    logic [CORE_W-1:0]    pick_idx;
    grant_kind_e          kind;

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end
    assign slot_idx = slot_q;

    slot_table #(
        .NUM_CORES(NUM_CORES), .NUM_SLOTS(NUM_SLOTS),
        .CORE_W(CORE_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .waddr(tbl_addr), .wowner(tbl_owner),
        .raddr(slot_q), .rowner(owner), .owns_none(owns_none)
    );

    assign elig = core_req & core_en & owns_none;

    mooch_picker #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .elig(elig), .advance(kind == GK_MOOCH),
        .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    always_comb begin
        if (core_req[owner] && core_en[owner]) kind = GK_OWNER;
        else if (pick_valid)                   kind = GK_MOOCH;
        else                                   kind = GK_NONE;
    end

    always_comb begin
        unique case (kind)
            GK_OWNER: core_grant = ONE << owner;
            GK_MOOCH: core_grant = ONE << pick_idx;
            GK_NONE:  core_grant = '0;
            default:  core_grant = '0;
        endcase
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_grant)); // R7
    AST_NO_STRAY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_grant & ~(core_req & core_en)) == '0); // R6
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> slot_idx == $past(slot_idx) + 1'b1); // R2
    AST_OWNER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req[owner] && core_en[owner]) |-> core_grant[owner]); // R3
    AST_LEND_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_grant != '0 && !core_grant[owner]) |-> ((core_grant & owns_none) == core_grant)); // R4
endmodule

// File: tb/hub_slot_arbiter_bench.sv
`timescale 1ns/1ps
module hub_slot_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0, en = '0;
    logic        we = 1'b0;
    logic [6:0]  waddr = '0;
    logic [4:0]  wown = '0;
    logic [31:0] grant;
    logic [6:0]  slot;

    int errors = 0, checks = 0;
    int mtbl[128];
    int mptr, mslot;
    bit done = 0;

    always #2.5 clk = ~clk;

    hub_slot_arbiter u_hub_slot_arbiter (
        .clk(clk), .rst_n(rst_n), .core_req(req), .core_en(en),
        .tbl_we(we), .tbl_addr(waddr), .tbl_owner(wown),
        .core_grant(grant), .slot_idx(slot)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (slot %0d)", tag, got, exp, mslot);
        end
    endtask

    function automatic int owned(input int c);
        int n = 0;
        for (int i = 0; i < 128; i++) if (mtbl[i] == c) n++;
        return n;
    endfunction

    task automatic predict(input logic [31:0] r, input logic [31:0] e,
                           output logic [31:0] g, output int gi, output bit mo);
        int ow;
        g = '0; gi = -1; mo = 0;
        ow = mtbl[mslot];
        if (r[ow] && e[ow]) begin
            g = 32'd1 << ow; gi = ow;
        end else begin
            for (int k = 0; k < 32; k++) begin
                int c;
                c = (mptr + k) % 32;
                if (gi < 0 && r[c] && e[c] && owned(c) == 0) begin
                    g = 32'd1 << c; gi = c; mo = 1;
                end
            end
        end
    endtask

    task automatic cyc(input logic [31:0] r, input logic [31:0] e,
                       input bit w, input int a, input int o, input string tag);
        logic [31:0] eg;
        int gi;
        bit mo;
        string t;
        @(negedge clk);
        req = r; en = e; we = w; waddr = a[6:0]; wown = o[4:0];
        #1;
        predict(r, e, eg, gi, mo);
        t = tag;
        if (t == "") begin
            if (w)                 t = "R8";
            else if (mo)           t = "R4";
            else if (eg != 0)      t = "R3";
            else if ((r & e) != 0) t = "R4";
            else                   t = "R7";
        end
        check(t, grant, eg);
        check("R2", {25'd0, slot}, mslot);
        check("R6", grant & ~e, 32'd0);
        check("R7", ($countones(grant) > 1) ? 32'd1 : 32'd0, 32'd0);
        @(posedge clk);
        mslot = (mslot + 1) % 128;
        if (w) mtbl[a] = o;
        if (mo) mptr = (gi + 1) % 32;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mtbl[i] = i % 32;
        mptr = 0; mslot = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1", grant, 32'd0);
        check("R1", {25'd0, slot}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        mslot = 1;
        // R1: round-robin ownership after reset
        for (int n = 0; n < 32; n++) cyc(32'd1 << (mslot % 32), '1, 0, 0, 0, "R1");
        // R2: idle run across the wrap
        for (int n = 0; n < 100; n++) cyc('0, '1, 0, 0, 0, "R2");
        // owners only
        for (int n = 0; n < 300; n++) cyc($urandom, '1, 0, 0, 0, "");
        // R9: strip cores 28..31 of every entry
        for (int i = 0; i < 128; i++)
            if (mtbl[i] >= 28) cyc('0, '1, 1, i, i % 28, "R8");
        for (int n = 0; n < 8; n++) cyc(32'd1 << 28, '1, 0, 0, 0, "R9");
        cyc('0, '1, 1, 5, 29, "R8");
        for (int n = 0; n < 128; n++) cyc(32'd1 << 29, '1, 0, 0, 0, "R9");
        // R5: rotating moochers 28, 30, 31
        for (int n = 0; n < 12; n++) cyc(32'hD000_0000, '1, 0, 0, 0, "R5");
        // R8: rewrite the slot under arbitration
        for (int n = 0; n < 6; n++) begin
            int ow;
            ow = mtbl[mslot];
            cyc((32'd1 << ow) | (32'd1 << ((ow + 7) % 28)), '1, 1, mslot, (ow + 7) % 28, "R8");
        end
        // R6: disabled owners
        for (int n = 0; n < 200; n++) cyc($urandom, $urandom, 0, 0, 0, "");
        // mixed traffic with random writes
        for (int n = 0; n < 2000; n++) begin
            bit w;
            w = ($urandom % 8) == 0;
            cyc($urandom | $urandom, ~($urandom & $urandom & $urandom), w,
                $urandom % 128, $urandom % 24, "");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule